// File: doc/BRIEF.md
# UART Receive Address Filter

This block sits between the character output of a UART receiver and the write port of its receive buffer, on multidrop links where many nodes share one line. A character with its most significant bit set is an address marker; each node passes only the traffic that follows its own address. The block holds match registers (two by default), each with its own enable bit in a control register. When any enable is set, an address character is compared with every enabled match register. A hit forwards that character and opens a pass window for the data characters after it. A miss discards the character and closes the window until the next address character.

When all enables are clear, the filter is transparent: every character goes to the buffer. Configuration uses a plain write strobe with a register index and a data byte. The current control register is brought out so its state can be seen. Deserialization, parity, the buffer and interrupts live elsewhere.

Top module: `uart_addr_filter`

## Requirements
- R1: After reset, the control register reads 0x0F, all enables are clear, both match registers hold 0x00, and the buffer-write strobe is low.
- R2: While all enables are clear, every valid character is forwarded unchanged, whatever its most significant bit, including back-to-back characters.
- R3: Register index 0 is match register A, index 1 is match register B, and index 2 is the control register. Control bit 7 enables register A and bit 6 enables register B. The other control bits are stored but have no effect on filtering.
- R4: When at least one enable is set, an address character (bit 7 = 1) equal to an enabled match register is forwarded and opens the pass window.
- R5: When at least one enable is set, an address character that equals no enabled match register is discarded and closes the window. A register whose enable is clear never produces a hit.
- R6: When at least one enable is set, a data character (bit 7 = 0) is forwarded only while the window is open. The window changes only on address characters.
- R7: With both enables set, an address character is a hit if it equals either match register.
- R8: A write to a match register while its own enable is set is ignored, and the register keeps its old value.
- R9: While all enables are clear, the window is held open. After an enable is set, data passes until the first address character arrives, and clearing all enables makes the next character pass at once.
- R10: Each forwarded character produces a buffer-write strobe exactly one cycle after its valid strobe, lasting one cycle, with the character on the data output. Discarded characters produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register index (0 match A, 1 match B, 2 control) |
| cfg_data | input | 8 | Register write data |
| ctrl_q | output | 8 | Current control register value |
| rx_valid | input | 1 | Received character valid |
| rx_char | input | 8 | Received character |
| buf_we | output | 1 | Buffer write strobe |
| buf_char | output | 8 | Character for the buffer |

## Verification
The bench builds the block with its defaults: 8-bit characters, two match registers and a 2-bit register index. This brings in reach both single-enable cases, with the other register's value set up to tempt a false hit, the dual-enable OR case, the locked-write case in both enable states, and the window rules around enable changes. Every character is checked one cycle after it is presented, and a strobe is also checked to fall in the cycle after that.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  typedef enum logic {
    WIN_DROP = 1'b0,
    WIN_PASS = 1'b1
  } win_state_t;

  localparam int unsigned CHAR_W_DEF    = 8;
  localparam int unsigned MATCH_CNT_DEF = 2;
endpackage

// File: rtl/addr_filt_regs.sv
module addr_filt_regs #(
  parameter int unsigned CHAR_W    = 8,
  parameter int unsigned MATCH_CNT = 2,
  parameter int unsigned IDX_W     = 2,
  parameter logic [CHAR_W-1:0] CTRL_RST = 8'h0F
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [CHAR_W-1:0]                cfg_data,
  output logic [CHAR_W-1:0]                ctrl_q,
  output logic [MATCH_CNT-1:0]             en,
  output logic [MATCH_CNT-1:0][CHAR_W-1:0] match_q
);
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(MATCH_CNT);

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= CTRL_RST;
    else if (cfg_we && cfg_idx == CTRL_IDX) ctrl_q <= cfg_data;
  end

  for (genvar i = 0; i < MATCH_CNT; i++) begin : g_match
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    assign en[i] = ctrl_q[CHAR_W-1-i];

    always_ff @(posedge clk) begin
      if (rst)                                        match_q[i] <= '0;
      else if (cfg_we && cfg_idx == MY_IDX && !en[i]) match_q[i] <= cfg_data;
    end

    assert_locked_R8: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_idx == MY_IDX && en[i]) |=> $stable(match_q[i]));
  end
endmodule

// File: rtl/addr_filt_cmp.sv
module addr_filt_cmp #(
  parameter int unsigned CHAR_W    = 8,
  parameter int unsigned MATCH_CNT = 2
) (
  input  logic [CHAR_W-1:0]                ch,
  input  logic [MATCH_CNT-1:0]             en,
  input  logic [MATCH_CNT-1:0][CHAR_W-1:0] match_q,
  output logic                             any_en,
  output logic                             hit
);
  logic [MATCH_CNT-1:0] hit_vec;

  for (genvar i = 0; i < MATCH_CNT; i++) begin : g_cmp
    assign hit_vec[i] = en[i] && (ch == match_q[i]);
  end

  assign any_en = |en;
  assign hit    = |hit_vec;
endmodule

// File: rtl/addr_filt_gate.sv
module addr_filt_gate
  import addr_filt_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              any_en,
  input  logic              hit,
  output logic              out_we,
  output logic [CHAR_W-1:0] out_char
);
  localparam int unsigned MSB = CHAR_W - 1;

  win_state_t win_q;
  logic       is_addr;
  logic       pass;

  assign is_addr = in_char[MSB];
  assign pass    = !any_en || (is_addr ? hit : (win_q == WIN_PASS));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= WIN_DROP;
      out_we   <= 1'b0;
      out_char <= '0;
    end else begin
      out_we <= in_valid && pass;
      if (in_valid) out_char <= in_char;
      if (!any_en)                  win_q <= WIN_PASS;
      else if (in_valid && is_addr) win_q <= hit ? WIN_PASS : WIN_DROP;
    end
  end

  assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !any_en) |=> (out_we && out_char == $past(in_char)));
  assert_addr_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && any_en && is_addr && hit) |=> out_we);
  assert_addr_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && any_en && is_addr && !hit) |=> !out_we);
  assert_data_closed_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && any_en && !is_addr && win_q == WIN_DROP) |=> !out_we);
  assert_force_open_R9: assert property (@(posedge clk) disable iff (rst)
    !any_en |=> (win_q == WIN_PASS));
  assert_strobe_src_R10: assert property (@(posedge clk) disable iff (rst)
    out_we |-> $past(in_valid));
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int unsigned CHAR_W    = CHAR_W_DEF,
  parameter int unsigned MATCH_CNT = MATCH_CNT_DEF,
  parameter int unsigned IDX_W     = $clog2(MATCH_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CHAR_W-1:0] cfg_data,
  output logic [CHAR_W-1:0] ctrl_q,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              buf_we,
  output logic [CHAR_W-1:0] buf_char
);
  logic [MATCH_CNT-1:0]             en;
  logic [MATCH_CNT-1:0][CHAR_W-1:0] match_q;
  logic                             any_en;
  logic                             hit;

  addr_filt_regs #(.CHAR_W(CHAR_W), .MATCH_CNT(MATCH_CNT), .IDX_W(IDX_W)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .ctrl_q(ctrl_q), .en(en), .match_q(match_q)
  );

  addr_filt_cmp #(.CHAR_W(CHAR_W), .MATCH_CNT(MATCH_CNT)) i_cmp (
    .ch(rx_char), .en(en), .match_q(match_q), .any_en(any_en), .hit(hit)
  );

  addr_filt_gate #(.CHAR_W(CHAR_W)) i_gate (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_char(rx_char),
    .any_en(any_en), .hit(hit), .out_we(buf_we), .out_char(buf_char)
  );
endmodule

// File: tb/test_uart_addr_filter.sv
module test_uart_addr_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic [7:0] ctrl_q;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic       buf_we;
  logic [7:0] buf_char;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  uart_addr_filter i_uart_addr_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .ctrl_q(ctrl_q), .rx_valid(rx_valid),
    .rx_char(rx_char), .buf_we(buf_we), .buf_char(buf_char)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Present one character, then check the strobe one cycle later.
  task automatic send(input string req, input logic [7:0] c, input logic pass);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
    check(req, {7'd0, buf_we, (pass ? buf_char : 8'h00)}, {7'd0, pass, (pass ? c : 8'h00)});
  endtask

  task automatic t_reset_R1;
    check("R1 ctrl", {8'h00, ctrl_q}, 16'h000F);
    check("R1 strobe", {15'd0, buf_we}, 16'h0000);
  endtask

  task automatic t_passthru_R2;
    send("R2 0x00", 8'h00, 1'b1);
    send("R2 0xFF", 8'hFF, 1'b1);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 8'h80;
    @(negedge clk);
    rx_char = 8'h7F;
    check("R2 b2b first", {7'd0, buf_we, buf_char}, 16'h0180);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R2 b2b second", {7'd0, buf_we, buf_char}, 16'h017F);
    @(negedge clk);
    check("R10 strobe falls", {15'd0, buf_we}, 16'h0000);
  endtask

  task automatic t_single_a;
    wr(2'd0, 8'h85);
    wr(2'd1, 8'h86);
    wr(2'd2, 8'h8F);
    check("R3 ctrl value", {8'h00, ctrl_q}, 16'h008F);
    send("R9 data before first address", 8'h33, 1'b1);
    send("R5 miss (B disabled)", 8'h86, 1'b0);
    send("R6 data after miss", 8'h33, 1'b0);
    send("R4 hit A", 8'h85, 1'b1);
    send("R6 data after hit", 8'h12, 1'b1);
    @(negedge clk);
    check("R10 single pulse", {15'd0, buf_we}, 16'h0000);
    send("R5 miss closes", 8'h86, 1'b0);
    send("R6 data dropped", 8'h44, 1'b0);
  endtask

  task automatic t_single_b;
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'hA0);
    wr(2'd2, 8'h4F);
    send("R9 still open after enable", 8'h01, 1'b1);
    send("R5 A value, A disabled", 8'h85, 1'b0);
    send("R3 hit B", 8'hA0, 1'b1);
    send("R6 data after B hit", 8'h05, 1'b1);
  endtask

  task automatic t_both_R7;
    wr(2'd2, 8'hCF);
    send("R7 hit A", 8'h85, 1'b1);
    send("R7 data", 8'h01, 1'b1);
    send("R7 hit B", 8'hA0, 1'b1);
    send("R7 miss", 8'h99, 1'b0);
    send("R7 data dropped", 8'h02, 1'b0);
    send("R7 hit B again", 8'hA0, 1'b1);
  endtask

  task automatic t_lock_R8;
    wr(2'd0, 8'h90);
    send("R8 locked write ignored", 8'h90, 1'b0);
    send("R8 old value kept", 8'h85, 1'b1);
    wr(2'd2, 8'h4F);
    wr(2'd0, 8'h90);
    wr(2'd2, 8'hCF);
    send("R8 unlocked write taken", 8'h90, 1'b1);
    send("R8 old value gone", 8'h85, 1'b0);
  endtask

  task automatic t_clear_R9;
    send("R9 window closed", 8'h22, 1'b0);
    wr(2'd2, 8'h00);
    send("R9 immediate pass", 8'h22, 1'b1);
    send("R9 address passes", 8'hEE, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_R1();
    t_passthru_R2();
    t_single_a();
    t_single_b();
    t_both_R7();
    t_lock_R8();
    t_clear_R9();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule